// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers six interrupt sources for a small 8-bit processor core. The sources are two external pins, a timer overflow, a time-base timeout, an analog-to-digital end-of-conversion and a real-time-clock timeout. Each source has a sticky request flag and its own enable bit. A global master enable gates all six. The core reads and writes these bits through two byte-wide control registers.

Pending requests are judged only at the core's instruction-boundary strobe. At that strobe, if the master enable is set and the return stack has room, the highest-priority enabled pending source is accepted. When a source is accepted:
- the block issues a one-cycle call pulse together with that source's vector address;
- it clears the accepted source's flag;
- it clears the master enable, so nested interrupts are blocked until software re-enables them.

A return event from the core may or may not re-enable interrupts, depending on a qualifier bit. The external pins are synchronized and then edge-detected, and the active edge is selected by an input.

Top module: `irq_vector_ctl`

## Requirements
- R1: When several enabled sources are pending at one strobe, exactly one is accepted. The order from highest priority to lowest is: external 0, external 1, timer, time base, A/D, RTC.
- R2: The vector address on `call_vec` is 0x004, 0x008, 0x00C, 0x010, 0x014 or 0x018 for external 0, external 1, timer, time base, A/D and RTC respectively.
- R3: A request flag, once set, stays set until its source is accepted or software writes 0 to it. Software may also write 1 to it.
- R4: A source is accepted only on a clock edge where `cyc_strobe` is 1, the master enable is 1, its own enable is 1 and `stack_full` is 0. `call_req` is then 1 for the single cycle that follows that edge.
- R5: Accepting a source clears that source's flag and the master enable in the same edge. All other flags and enables are kept.
- R6: A request raised on the same edge as a strobe, or at any point between two strobes, is not accepted before the next strobe.
- R7: A return event (`ret_evt`=1) with `ret_reen`=1 sets the master enable, unless a source is accepted on that edge. With `ret_reen`=0 the return event leaves the master enable unchanged.
- R8: External flags are set from the synchronized pins. `edge_sel[0]`=1 selects rising edges and `edge_sel[1]`=1 selects falling edges; both bits together select both edges, and 00 selects none. The flag reads 1 after the third rising clock edge following the pin change.
- R9: Control register 0 (`reg_sel`=0) has these bits: 0 master enable, 1/2/3 enables for external 0/external 1/timer, 4/5/6 flags for external 0/external 1/timer. Control register 1 (`reg_sel`=1) has these bits: 1/2/3 enables for time base/A/D/RTC, 4/5/6 flags for time base/A/D/RTC. Unused bits read 0.
- R10: If a hardware request and a software write hit the same flag on the same edge, the flag ends up 1.
- R11: After reset, every flag, every enable and the master enable are 0, and `call_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 2 | Asynchronous external request pins |
| edge_sel | input | 2 | Active edge select: bit 0 rising, bit 1 falling |
| tmr_ovf | input | 1 | Timer overflow pulse |
| tbase_to | input | 1 | Time-base timeout pulse |
| adc_eoc | input | 1 | A/D end-of-conversion pulse |
| rtc_to | input | 1 | RTC timeout pulse |
| cyc_strobe | input | 1 | Instruction-boundary sampling strobe |
| stack_full | input | 1 | Return stack has no free entry |
| ret_evt | input | 1 | Core executes a return |
| ret_reen | input | 1 | Qualifies ret_evt: 1 re-enables interrupts |
| reg_sel | input | 1 | Control register select |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Selected control register contents |
| call_req | output | 1 | One-cycle interrupt call request |
| call_vec | output | VEC_W | Vector address of the accepted source |

## Verification
The block is driven with the following patterns:
- A single request, so each vector can be tied to its own source.
- Four requests raised on one edge and drained one return at a time, which exposes the priority order.
- A request landing on the strobe edge itself, which shows whether judging is truly delayed to the next strobe.
- Requests blocked by a clear own enable, by a clear master enable and by a full stack; these separate the three gating conditions.
- Pin toggles under each of the four edge-select settings, with the flag checked two and three edges after the change, which pins down both the edge filter and the synchronizer latency.
- A write racing a hardware set on the same flag, which shows which of the two wins.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NSRC     = 6;
    localparam int NEXT     = 2;
    localparam int REG_W    = 8;
    localparam int PER_REG  = 3;
    localparam int EN_LSB   = 1;
    localparam int FLAG_LSB = 4;

    typedef enum logic [2:0] {
        SRC_EXT0  = 3'd0,
        SRC_EXT1  = 3'd1,
        SRC_TMR   = 3'd2,
        SRC_TBASE = 3'd3,
        SRC_ADC   = 3'd4,
        SRC_RTC   = 3'd5
    } irq_src_e;

    typedef struct packed {
        logic     valid;
        irq_src_e src;
    } irq_pick_t;

    function automatic logic [7:0] vec_of(irq_src_e s);
        return 8'((int'(s) + 1) * 4);
    endfunction

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin,
    input  logic [1:0]   edge_sel,
    output logic [N-1:0] hit
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        logic s1, s2, s3;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
                s3 <= 1'b0;
            end else begin
                s1 <= pin[g];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign hit[g] = (edge_sel[0] & s2 & ~s3) | (edge_sel[1] & ~s2 & s3);
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] req,
    output irq_pick_t    pick
);
    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick.valid = 1'b1;
                pick.src   = irq_src_e'(3'(i));
            end
        end
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
#(
    parameter int N = NSRC,
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] hw_set,
    input  logic         take,
    input  irq_src_e     take_src,
    input  logic         reen,
    input  logic         reg_sel,
    input  logic         reg_we,
    input  logic [W-1:0] wdata,
    output logic [N-1:0] flags,
    output logic [N-1:0] en,
    output logic         emi,
    output logic [W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            en    <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (hw_set[i])
                    flags[i] <= 1'b1;
                else if (take && (int'(take_src) == i))
                    flags[i] <= 1'b0;
                else if (reg_we && ((i / PER_REG) == int'(reg_sel)))
                    flags[i] <= wdata[FLAG_LSB + (i % PER_REG)];
                if (reg_we && ((i / PER_REG) == int'(reg_sel)))
                    en[i] <= wdata[EN_LSB + (i % PER_REG)];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            emi <= 1'b0;
        else if (take)
            emi <= 1'b0;
        else if (reen)
            emi <= 1'b1;
        else if (reg_we && !reg_sel)
            emi <= wdata[0];
    end

    always_comb begin
        rdata = '0;
        if (!reg_sel)
            rdata[0] = emi;
        for (int i = 0; i < N; i++) begin
            if ((i / PER_REG) == int'(reg_sel)) begin
                rdata[FLAG_LSB + (i % PER_REG)] = flags[i];
                rdata[EN_LSB + (i % PER_REG)]   = en[i];
            end
        end
    end
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
    import irq_pkg::*;
#(
    parameter int VEC_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       ext_pin,
    input  logic [1:0]       edge_sel,
    input  logic             tmr_ovf,
    input  logic             tbase_to,
    input  logic             adc_eoc,
    input  logic             rtc_to,
    input  logic             cyc_strobe,
    input  logic             stack_full,
    input  logic             ret_evt,
    input  logic             ret_reen,
    input  logic             reg_sel,
    input  logic             reg_we,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             call_req,
    output logic [VEC_W-1:0] call_vec
);
    logic [NEXT-1:0] ext_hit;
    logic [NSRC-1:0] hw_set;
    logic [NSRC-1:0] flags;
    logic [NSRC-1:0] en;
    logic            mstr_en;
    logic            take;
    irq_pick_t       pick;

    irq_edge_sync #(.N(NEXT)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin      (ext_pin),
        .edge_sel (edge_sel),
        .hit      (ext_hit)
    );

    assign hw_set = {rtc_to, adc_eoc, tbase_to, tmr_ovf, ext_hit};

    irq_arbiter #(.N(NSRC)) u_arb (
        .req  (flags & en),
        .pick (pick)
    );

    assign take = cyc_strobe & mstr_en & ~stack_full & pick.valid;

    irq_flag_bank #(.N(NSRC), .W(REG_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .hw_set   (hw_set),
        .take     (take),
        .take_src (pick.src),
        .reen     (ret_evt & ret_reen),
        .reg_sel  (reg_sel),
        .reg_we   (reg_we),
        .wdata    (reg_wdata),
        .flags    (flags),
        .en       (en),
        .emi      (mstr_en),
        .rdata    (reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            call_req <= 1'b0;
            call_vec <= '0;
        end else begin
            call_req <= take;
            if (take)
                call_vec <= VEC_W'(vec_of(pick.src));
        end
    end
endmodule

// File: rtl/irq_vector_chk.sv
module irq_vector_chk #(
    parameter int VEC_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             cyc_strobe,
    input logic             stack_full,
    input logic             ret_evt,
    input logic             ret_reen,
    input logic             emi,
    input logic [7:0]       reg_rdata,
    input logic             call_req,
    input logic [VEC_W-1:0] call_vec
);
    // R4
    call_single_chk: assert property (@(posedge clk) disable iff (rst)
        call_req |=> !call_req);
    // R4
    call_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        call_req |-> ($past(cyc_strobe) && !$past(stack_full)));
    // R5
    call_clears_emi_chk: assert property (@(posedge clk) disable iff (rst)
        call_req |-> !emi);
    // R7
    reen_sets_emi_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ret_evt && ret_reen) && !call_req) |-> emi);
    // R2
    legal_vec_chk: assert property (@(posedge clk) disable iff (rst)
        call_req |-> (call_vec[1:0] == 2'b00 && call_vec >= VEC_W'(4) && call_vec <= VEC_W'(24)));
    // R9
    top_bit_zero_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[7] == 1'b0);
endmodule

bind irq_vector_ctl irq_vector_chk #(.VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cyc_strobe (cyc_strobe),
    .stack_full (stack_full),
    .ret_evt    (ret_evt),
    .ret_reen   (ret_reen),
    .emi        (mstr_en),
    .reg_rdata  (reg_rdata),
    .call_req   (call_req),
    .call_vec   (call_vec)
);

// File: tb/irq_vector_ctl_bench.sv
module irq_vector_ctl_bench;
    localparam int CLK_PER = 10;
    localparam int VW = 12;

    logic          clk = 0;
    logic          rst = 1;
    logic [1:0]    ext_pin = 0;
    logic [1:0]    edge_sel = 0;
    logic          tmr_ovf = 0, tbase_to = 0, adc_eoc = 0, rtc_to = 0;
    logic          cyc_strobe = 0, stack_full = 0, ret_evt = 0, ret_reen = 0;
    logic          reg_sel = 0, reg_we = 0;
    logic [7:0]    reg_wdata = 0;
    logic [7:0]    reg_rdata;
    logic          call_req;
    logic [VW-1:0] call_vec;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PER/2) clk = ~clk;

    irq_vector_ctl #(.VEC_W(VW)) u_irq_vector_ctl (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .edge_sel(edge_sel),
        .tmr_ovf(tmr_ovf), .tbase_to(tbase_to), .adc_eoc(adc_eoc), .rtc_to(rtc_to),
        .cyc_strobe(cyc_strobe), .stack_full(stack_full),
        .ret_evt(ret_evt), .ret_reen(ret_reen),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .call_req(call_req), .call_vec(call_vec)
    );

    // reference model
    bit m_flag[6];
    bit m_en[6];
    bit m_emi;
    bit m_p1[2], m_p2[2], m_p3[2];
    bit m_call;
    int m_vec;

    function automatic int model_read(bit sel);
        int r = 0;
        if (!sel) r = r | int'(m_emi);
        for (int i = 0; i < 6; i++)
            if ((i / 3) == int'(sel))
                r = r | (int'(m_flag[i]) << (4 + i % 3)) | (int'(m_en[i]) << (1 + i % 3));
        return r;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit hs[6];
        int pick;
        bit tk;
        if (rst) begin
            for (int i = 0; i < 6; i++) begin m_flag[i] = 0; m_en[i] = 0; end
            for (int k = 0; k < 2; k++) begin m_p1[k] = 0; m_p2[k] = 0; m_p3[k] = 0; end
            m_emi = 0; m_call = 0; m_vec = 0;
        end else begin
            for (int k = 0; k < 2; k++) begin
                hs[k] = (edge_sel[0] && m_p2[k] && !m_p3[k]) || (edge_sel[1] && !m_p2[k] && m_p3[k]);
                m_p3[k] = m_p2[k]; m_p2[k] = m_p1[k]; m_p1[k] = ext_pin[k];
            end
            hs[2] = tmr_ovf; hs[3] = tbase_to; hs[4] = adc_eoc; hs[5] = rtc_to;
            pick = -1;
            for (int i = 5; i >= 0; i--) if (m_flag[i] && m_en[i]) pick = i;
            tk = cyc_strobe && m_emi && !stack_full && (pick >= 0);
            for (int i = 0; i < 6; i++) begin
                if (hs[i]) m_flag[i] = 1;
                else if (tk && pick == i) m_flag[i] = 0;
                else if (reg_we && (i / 3) == int'(reg_sel)) m_flag[i] = reg_wdata[4 + i % 3];
                if (reg_we && (i / 3) == int'(reg_sel)) m_en[i] = reg_wdata[1 + i % 3];
            end
            if (tk) m_emi = 0;
            else if (ret_evt && ret_reen) m_emi = 1;
            else if (reg_we && !reg_sel) m_emi = reg_wdata[0];
            m_call = tk;
            if (tk) m_vec = (pick + 1) * 4;
        end
        #1;
        check("R4 model call_req", int'(call_req), int'(m_call));
        if (m_call) check("R1/R2 model call_vec", int'(call_vec), m_vec);
        check("R9 model reg_rdata", int'(reg_rdata), model_read(reg_sel));
    end

    task automatic tick();
        @(posedge clk); #3;
    endtask

    task automatic wr(bit sel, logic [7:0] d);
        reg_sel = sel; reg_we = 1; reg_wdata = d; tick(); reg_we = 0;
    endtask

    task automatic rd(bit sel, int exp, string tag);
        reg_sel = sel; #1; check(tag, int'(reg_rdata), exp);
    endtask

    task automatic strobe(int exp_vec, string tag);
        cyc_strobe = 1; tick(); cyc_strobe = 0;
        check(tag, call_req ? int'(call_vec) : 0, exp_vec);
    endtask

    task automatic reti();
        ret_evt = 1; ret_reen = 1; tick(); ret_evt = 0; ret_reen = 0;
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        // R11 reset state
        rd(0, 0, "R11 reset ctl0"); rd(1, 0, "R11 reset ctl1");
        check("R11 reset call_req", int'(call_req), 0);

        // R9 register map
        wr(0, 8'h0F); wr(1, 8'h0E);
        rd(0, 'h0F, "R9 ctl0 enables"); rd(1, 'h0E, "R9 ctl1 enables");
        wr(1, 8'hFF); rd(1, 'h7E, "R9 unused bits zero");
        wr(1, 8'h0E);

        // R3, R4 stack full, R2, R5
        tmr_ovf = 1; tick(); tmr_ovf = 0;
        rd(0, 'h4F, "R3 timer flag latched");
        stack_full = 1; strobe(0, "R4 stack full blocks"); stack_full = 0;
        rd(0, 'h4F, "R3 flag held while blocked");
        strobe('h00C, "R2 timer vector");
        rd(0, 'h0E, "R5 flag and emi cleared");

        // R4 emi off, then R1 drain order with R7
        tmr_ovf = 1; tbase_to = 1; adc_eoc = 1; rtc_to = 1; tick();
        tmr_ovf = 0; tbase_to = 0; adc_eoc = 0; rtc_to = 0;
        strobe(0, "R4 master enable off blocks");
        rd(1, 'h7E, "R3 three flags pending");
        ret_evt = 1; ret_reen = 0; tick(); ret_evt = 0;
        rd(0, 'h4E, "R7 plain return keeps emi clear");
        reti(); rd(0, 'h4F, "R7 reenable return sets emi");
        strobe('h00C, "R1 timer first");
        reti(); strobe('h010, "R1 time base second");
        reti(); strobe('h014, "R1 adc third");
        reti(); strobe('h018, "R1 rtc last");

        // R4 own enable clear
        wr(0, 8'h0F); wr(1, 8'h00);
        adc_eoc = 1; tick(); adc_eoc = 0;
        strobe(0, "R4 own enable off blocks");
        rd(1, 'h20, "R3 disabled flag kept");
        wr(1, 8'h00); rd(1, 'h00, "R3 software clear");

        // R10 hw set beats sw write
        reg_sel = 1; reg_we = 1; reg_wdata = 8'h00; adc_eoc = 1; tick();
        reg_we = 0; adc_eoc = 0;
        rd(1, 'h20, "R10 hw set wins");
        wr(1, 8'h00);

        // R6 request on strobe edge waits for next strobe
        tmr_ovf = 1; cyc_strobe = 1; tick(); tmr_ovf = 0; cyc_strobe = 0;
        check("R6 no call on arrival edge", int'(call_req), 0);
        tick(); tick();
        strobe('h00C, "R6 taken at later strobe");

        // R8 edges
        wr(0, 8'h06);
        edge_sel = 2'b01; ext_pin[0] = 1; tick(); tick();
        rd(0, 'h06, "R8 two edges after change not yet");
        tick(); rd(0, 'h16, "R8 rising flag third edge");
        wr(0, 8'h06);
        ext_pin[0] = 0; repeat (4) tick(); rd(0, 'h06, "R8 rising-only ignores fall");
        edge_sel = 2'b10;
        ext_pin[0] = 1; repeat (4) tick(); rd(0, 'h06, "R8 falling-only ignores rise");
        ext_pin[0] = 0; repeat (4) tick(); rd(0, 'h16, "R8 falling flag");
        wr(0, 8'h06);
        edge_sel = 2'b00;
        ext_pin = 2'b11; repeat (4) tick(); rd(0, 'h06, "R8 none selected");
        edge_sel = 2'b11;
        ext_pin = 2'b00; repeat (4) tick(); rd(0, 'h36, "R8 both edges");
        wr(0, 8'h37);
        strobe('h004, "R1 ext0 over ext1");
        reti(); strobe('h008, "R2 ext1 vector");

        repeat (3) tick();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule